// File: doc/BRIEF.md
# Table-Encoded Programmable Clock Divider

This block divides a fast source clock by an even ratio chosen through a small selector field. The selector is not used as a plain count: it indexes an encoding table. Which table applies is fixed per instance by a generation parameter and a variant parameter. Some tables are non-linear in the selector, and one of them gives the same ratio for two selector values.

The block produces a divided clock with an exact 50% duty cycle, a one-cycle enable pulse at the end of every divided period, and the ratio currently in force. A selector value is captured on a load strobe and held pending. It takes effect only when the running period finishes, so the output never shows a shortened or stretched pulse. One instance type has a 2-bit selector instead of the usual 3-bit field.

Top module: `clkdiv_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `div_clk_o` and `div_en_o` are 0 and `ratio_o` equals the table entry for selector value RESET_SEL (default 0).
- R2: With GEN=1, selector s (0..7) maps to ratio 2*(s+1), i.e. 2 up to 16; the network variant (NET_VARIANT=1) uses this same table.
- R3: With GEN=2 and NET_VARIANT=0, selector s maps to ratio 4*(s+1), i.e. 4 up to 32.
- R4: With GEN=2 and NET_VARIANT=1, selectors 0 and 1 both map to ratio 4, and selector s in 2..7 maps to 2*(s+1).
- R5: With SEL_W=2, the 2-bit selector is zero-extended, so it uses the first four entries of the instance's table.
- R6: After the rising edge that starts a period, `div_clk_o` stays low for ratio/2 source cycles and then high for ratio/2 source cycles. Counting from the release of reset, it goes high after the (ratio/2)-th rising edge.
- R7: `div_en_o` is high for exactly one cycle per period: the cycle in which `div_clk_o` has just returned low.
- R8: A load captures `sel_i`. The new ratio appears on `ratio_o` and governs the waveform only from the end of the period that is running. Until then both are unchanged.
- R9: When several loads arrive within one period, the last of them is the one applied.
- R10: A load in the cycle whose edge ends a period is not applied at that boundary; it is applied at the next one.
- R11: Changes on `sel_i` without a load have no effect on `ratio_o` or on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sel_i | input | SEL_W | Ratio selector field |
| load_i | input | 1 | Strobe that captures `sel_i` as the pending selector |
| div_clk_o | output | 1 | Divided clock, 50% duty |
| div_en_o | output | 1 | One-cycle pulse at each period end |
| ratio_o | output | RATIO_W (6) | Division ratio currently in force |

## Verification
Every output is registered. A period end therefore shows on `div_clk_o`, `div_en_o` and `ratio_o` right after the rising edge that completes the ratio-th cycle. A load shows up in the outputs only at the next such edge, not the edge that captured it. The bench drives inputs on the falling edge and advances its own position-in-period model once per rising edge. It then compares all three outputs of five differently configured instances on the following falling edge. The directed cases aim loads at the cycle just before a boundary, and at two consecutive cycles inside one period, to pin down exactly which edge adopts the new ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int MAX_RATIO = 32;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
  localparam int IDX_W     = 3;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } pend_t;

  // Selector-to-ratio encoding; gen picks the table family, net the variant.
  function automatic logic [RATIO_W-1:0] ratio_lookup(input int gen,
                                                      input logic net,
                                                      input logic [IDX_W-1:0] s);
    logic [RATIO_W-1:0] r;
    if (gen == 1) begin
      case (s)
        3'd0: r = 6'd2;   3'd1: r = 6'd4;   3'd2: r = 6'd6;   3'd3: r = 6'd8;
        3'd4: r = 6'd10;  3'd5: r = 6'd12;  3'd6: r = 6'd14;  default: r = 6'd16;
      endcase
    end else if (net) begin
      case (s)
        3'd0: r = 6'd4;   3'd1: r = 6'd4;   3'd2: r = 6'd6;   3'd3: r = 6'd8;
        3'd4: r = 6'd10;  3'd5: r = 6'd12;  3'd6: r = 6'd14;  default: r = 6'd16;
      endcase
    end else begin
      case (s)
        3'd0: r = 6'd4;   3'd1: r = 6'd8;   3'd2: r = 6'd12;  3'd3: r = 6'd16;
        3'd4: r = 6'd20;  3'd5: r = 6'd24;  3'd6: r = 6'd28;  default: r = 6'd32;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_sel_stage.sv
module clkdiv_sel_stage
  import clkdiv_pkg::*;
#(
  parameter int RESET_SEL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             load_i,
  input  logic             wrap_i,
  output logic [IDX_W-1:0] applied_o
);

  pend_t            pend_q;
  logic [IDX_W-1:0] applied_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      applied_q <= IDX_W'(RESET_SEL);
    end else begin
      if (wrap_i && pend_q.valid) applied_q <= pend_q.idx;
      if (load_i)      pend_q <= '{valid: 1'b1, idx: idx_i};
      else if (wrap_i) pend_q.valid <= 1'b0;
    end
  end

  assign applied_o = applied_q;

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               wrap_o,
  output logic               clk_o,
  output logic               en_o
);

  logic [RATIO_W-1:0] half_w;
  logic [RATIO_W-1:0] cnt_q;
  logic               clk_q;
  logic               en_q;
  logic               toggle_w;

  assign half_w   = ratio_i >> 1;
  assign toggle_w = (cnt_q == half_w - 1'b1);
  assign wrap_o   = toggle_w && clk_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= toggle_w ? '0 : cnt_q + 1'b1;
      clk_q <= clk_q ^ toggle_w;
      en_q  <= wrap_o;
    end
  end

  assign clk_o = clk_q;
  assign en_o  = en_q;

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int GEN         = 2,
  parameter bit NET_VARIANT = 1'b0,
  parameter int SEL_W       = 3,
  parameter int RESET_SEL   = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               load_i,
  output logic               div_clk_o,
  output logic               div_en_o,
  output logic [RATIO_W-1:0] ratio_o
);

  logic [IDX_W-1:0]   sel_ext_w;
  logic [IDX_W-1:0]   applied_sel_w;
  logic [RATIO_W-1:0] ratio_w;
  logic               wrap_w;

  generate
    if (SEL_W < IDX_W) begin : g_narrow
      assign sel_ext_w = {{(IDX_W-SEL_W){1'b0}}, sel_i};
    end else begin : g_full
      assign sel_ext_w = sel_i[IDX_W-1:0];
    end
  endgenerate

  clkdiv_sel_stage #(.RESET_SEL(RESET_SEL)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (sel_ext_w),
    .load_i    (load_i),
    .wrap_i    (wrap_w),
    .applied_o (applied_sel_w)
  );

  assign ratio_w = ratio_lookup(GEN, NET_VARIANT, applied_sel_w);

  clkdiv_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_w),
    .wrap_o  (wrap_w),
    .clk_o   (div_clk_o),
    .en_o    (div_en_o)
  );

  assign ratio_o = ratio_w;

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk
  import clkdiv_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               div_clk_o,
  input logic               div_en_o,
  input logic [RATIO_W-1:0] ratio_o
);

  logic [RATIO_W-1:0] hi_len_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) hi_len_q <= '0;
    else         hi_len_q <= div_clk_o ? hi_len_q + 1'b1 : '0;
  end

  // R7
  en_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o |-> (!div_clk_o && $past(div_clk_o)));

  // R7
  fall_has_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_clk_o) |-> div_en_o);

  // R8
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_en_o |-> $stable(ratio_o));

  // R6
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_clk_o) |-> (hi_len_q == ($past(ratio_o) >> 1)));

  // R2
  ratio_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_o[0] == 1'b0) && (ratio_o != '0));

endmodule

bind clkdiv_top clkdiv_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_clk_o (div_clk_o),
  .div_en_o  (div_en_o),
  .ratio_o   (ratio_o)
);

// File: tb/clkdiv_top_tb.sv
module clkdiv_top_tb;

  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = '0;
  logic       load = 1'b0;

  logic       dclk [N];
  logic       den  [N];
  logic [5:0] drat [N];

  int cfg_gen [N] = '{2, 2, 1, 1, 2};
  int cfg_net [N] = '{0, 1, 0, 1, 0};
  int cfg_w   [N] = '{3, 3, 3, 3, 2};

  int m_pos [N];
  int m_rat [N];
  int m_en  [N];
  int m_pv  [N];
  int m_ps  [N];

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string scen  = "run";

  always #10 clk = ~clk;

  clkdiv_top #(.GEN(2), .NET_VARIANT(1'b0), .SEL_W(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .load_i(load),
    .div_clk_o(dclk[0]), .div_en_o(den[0]), .ratio_o(drat[0]));
  clkdiv_top #(.GEN(2), .NET_VARIANT(1'b1), .SEL_W(3)) u_net2 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .load_i(load),
    .div_clk_o(dclk[1]), .div_en_o(den[1]), .ratio_o(drat[1]));
  clkdiv_top #(.GEN(1), .NET_VARIANT(1'b0), .SEL_W(3)) u_gen1 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .load_i(load),
    .div_clk_o(dclk[2]), .div_en_o(den[2]), .ratio_o(drat[2]));
  clkdiv_top #(.GEN(1), .NET_VARIANT(1'b1), .SEL_W(3)) u_gen1n (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .load_i(load),
    .div_clk_o(dclk[3]), .div_en_o(den[3]), .ratio_o(drat[3]));
  clkdiv_top #(.GEN(2), .NET_VARIANT(1'b0), .SEL_W(2)) u_narrow (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel[1:0]), .load_i(load),
    .div_clk_o(dclk[4]), .div_en_o(den[4]), .ratio_o(drat[4]));

  function automatic int exp_ratio(int i, int s);
    int v;
    v = s & ((1 << cfg_w[i]) - 1);
    if (cfg_gen[i] == 1) return 2 * (v + 1);
    if (cfg_net[i] != 0) return (v < 2) ? 4 : 2 * (v + 1);
    return 4 * (v + 1);
  endfunction

  function automatic string table_tag(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      4: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_pos[i] = 0; m_rat[i] = exp_ratio(i, 0);
      m_en[i] = 0;  m_pv[i] = 0; m_ps[i] = 0;
    end
  endtask

  task automatic model_edge(int s, bit l);
    for (int i = 0; i < N; i++) begin
      m_pos[i]++;
      m_en[i] = 0;
      if (m_pos[i] == m_rat[i]) begin
        m_pos[i] = 0;
        m_en[i]  = 1;
        if (m_pv[i] != 0) m_rat[i] = exp_ratio(i, m_ps[i]);
        m_pv[i] = 0;
      end
      if (l) begin m_pv[i] = 1; m_ps[i] = s; end
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < N; i++) begin
      check(int'(drat[i]) == m_rat[i], {table_tag(i), "/", scen}, int'(drat[i]), m_rat[i]);
      check(int'(dclk[i]) == int'(m_pos[i] >= m_rat[i] / 2), {"R6/", scen},
            int'(dclk[i]), int'(m_pos[i] >= m_rat[i] / 2));
      check(int'(den[i]) == m_en[i], {"R7/", scen}, int'(den[i]), m_en[i]);
    end
  endtask

  task automatic step(int s, bit l);
    sel  = 3'(s);
    load = l;
    @(posedge clk);
    model_edge(s, l);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(int'($urandom % 8), 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    load  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    for (int i = 0; i < N; i++) begin
      check(int'(drat[i]) == exp_ratio(i, 0), "R1", int'(drat[i]), exp_ratio(i, 0));
      check(dclk[i] == 1'b0, "R1", int'(dclk[i]), 0);
      check(den[i] == 1'b0, "R1", int'(den[i]), 0);
    end
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // table sweep on every instance (R2 R3 R4 R5 R8)
    scen = "R8";
    for (int s = 0; s < 8; s++) begin
      step(s, 1'b1);
      idle(80);
    end

    // R9: two loads inside one period, last one wins
    scen = "R9";
    while (m_pos[0] != 1) idle(1);
    step(3, 1'b1);
    step(6, 1'b1);
    idle(80);
    check(drat[0] == 6'd28, "R9", int'(drat[0]), 28);

    // R10: load on the boundary edge is deferred one period
    scen = "R10";
    while (m_pos[0] != m_rat[0] - 1) idle(1);
    step(1, 1'b1);
    check(drat[0] == 6'd28, "R10", int'(drat[0]), 28);
    check(den[0] == 1'b1, "R10", int'(den[0]), 1);
    idle(40);
    check(drat[0] == 6'd8, "R10", int'(drat[0]), 8);

    // R11: selector activity without load
    scen = "R11";
    idle(150);
    check(drat[0] == 6'd8, "R11", int'(drat[0]), 8);

    // constrained random mix
    scen = "rand";
    for (int k = 0; k < 3000; k++) step(int'($urandom % 8), ($urandom % 6) == 0);

    // reset in mid-run
    scen = "R1";
    do_reset();
    idle(100);

    summary();
    $finish;
  end

endmodule